// File: doc/BRIEF.md
# Serial Command/Data Mode Controller

This block sits between a host byte link (already deframed by a UART) and a bit-level bus engine. Every byte that arrives from the host is either a command or a payload byte for the bus. The block keeps two steady modes, command and data, and a one-byte check state that sits between them. In data mode each byte goes to the bus engine, and the byte that the engine returns is sent back to the host. In command mode each byte is decoded as a communication command (bus reset, single bit, pulse, search-accelerator control) or as a configuration read or write against a small file of 3-bit value codes.

The mode change is carried in the byte stream itself. In data mode the escape byte E3h is held back until the next byte arrives. A second E3h sends E3h to the bus once, so every byte value can still reach the bus. Any other byte ends data mode and is executed as a command. A break indication from the UART restores the power-on state, and the first byte after that is used only for calibration.

Top module: `sbus_mode_ctrl`

## Requirements
- R1: After reset, `rx_ready`=1, `tx_valid`=0 and `eng_req`=0, and the block is in command mode. The first byte accepted after reset is discarded: it starts no engine request and produces no response.
- R2: In command mode E1h switches to data mode and produces no response. In data mode any byte other than E3h (E1h included) starts one engine request with `eng_op`=0 (byte) and `eng_byte` equal to that byte. Exactly one response, equal to `eng_result`, follows `eng_done`.
- R3: In data mode E3h enters the check state and produces nothing. A second E3h starts one byte request carrying E3h and returns the block to data mode.
- R4: In the check state, a byte other than E3h is executed as a command, and the block is in command mode afterwards.
- R5: A byte with bit 7 = 0 and bit 0 = 1 is a configuration word. The parameter code is bits 6:4 and the value code is bits 3:1. A nonzero parameter code writes the value code and responds with {byte[7:1], 0}.
- R6: A configuration word with parameter code 000 reads the slot named by bits 3:1 and responds with {byte[7:4], stored code, 0}. The reset codes are 100 for slots 2 and 3 and 000 for all other slots. `cfg_codes` packs slot k at bits 3k-1:3k-3.
- R7: These bytes produce no response and no engine request: E3h and F1h in command mode, a configuration word with bit 0 = 0, a read of parameter 000, a communication byte with bit 0 = 0, and search-accelerator control.
- R8: A communication byte (bit 7 = 1, bit 0 = 1) selects its function in bits 6:5: 00 single bit (`eng_op`=1), 01 accelerator control (bit 4 latched to `eng_accel`), 10 bus reset (`eng_op`=2), 11 pulse. For single bit, accelerator control and bus reset, bits 3:2 are latched to `eng_speed`. Single bit and bus reset respond with `eng_result`.
- R9: A pulse byte starts `eng_op`=3, latches bit 1 to `eng_spu_arm` and bit 4 to `eng_pulse_hv`, and responds with {byte[7:2], 00} after `eng_done`. While a pulse is pending the block accepts bytes. F1h raises `eng_stop` for one cycle, and any other byte is discarded.
- R10: In command mode, after calibration, with no request or response pending, a cycle with `eng_presence`=1 and no accepted byte sends the unsolicited byte CDh (low bits 01). In data mode `eng_presence` is ignored.
- R11: Slot 6 is reserved. A write to it is echoed as in R5 but leaves its code at 000.
- R12: `brk_det`=1 at a clock edge has the same effect as reset. It restores the mode, the flags and the configuration defaults, and the next byte is again a calibration byte.
- R13: `eng_req` stays high until `eng_done`. A response holds `tx_valid` and `tx_data` until `tx_ready`, and no host byte is accepted while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_det | input | 1 | Break seen by the UART; soft master reset |
| rx_valid | input | 1 | Host byte valid |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Block can take a host byte |
| tx_valid | output | 1 | Response byte valid |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Host link takes the response |
| eng_req | output | 1 | Bus engine request, held until done |
| eng_op | output | 2 | 0 byte, 1 single bit, 2 bus reset, 3 pulse |
| eng_byte | output | 8 | Data byte or command byte for the engine |
| eng_speed | output | 2 | Latched bus speed code |
| eng_accel | output | 1 | Search accelerator on |
| eng_spu_arm | output | 1 | Strong pull-up after every data byte armed |
| eng_pulse_hv | output | 1 | Pulse type of the last pulse command |
| eng_stop | output | 1 | One-cycle request to end the pending pulse |
| eng_done | input | 1 | Engine finished the request |
| eng_result | input | 8 | Byte returned by the engine |
| eng_presence | input | 1 | Unsolicited presence pulse seen on the bus |
| cfg_codes | output | 21 | Packed configuration value codes, slots 1 to 7 |

## Verification
The bench targets the escape path: single E3h, doubled E3h, E1h sent as data, and an ordinary byte that arrives in the check state. A design that forwarded the first E3h, sent it twice, or stayed in data mode after the non-escape byte would show extra or missing engine requests, or payload bytes executed as configuration reads. It also checks the silent codes and the read of the reserved slot. A pulse is ended with F1h after a stray byte has arrived, so a design that executed bytes during the pulse or never raised the stop would give extra responses or an unchanged stop count. Presence in each mode, response back-pressure, and a break that has to restore the defaults and the calibration byte round out the set.

// File: rtl/smc_pkg.sv
// Shared constants and types for the serial mode controller.
// Assumes byte-wide host traffic and 3-bit configuration fields.
package smc_pkg;

    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 3;
    localparam int SLOT_CNT = 7;

    localparam logic [BYTE_W-1:0] CODE_GO_DATA = 8'hE1;
    localparam logic [BYTE_W-1:0] CODE_ESCAPE  = 8'hE3;
    localparam logic [BYTE_W-1:0] CODE_STOP    = 8'hF1;

    typedef enum logic [1:0] {
        OP_BYTE  = 2'd0,
        OP_BIT   = 2'd1,
        OP_RESET = 2'd2,
        OP_PULSE = 2'd3
    } eng_op_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_TO_DATA,
        K_CFG_WR,
        K_CFG_RD,
        K_BIT,
        K_ACCEL,
        K_RESET,
        K_PULSE
    } cmd_kind_e;

    typedef enum logic [1:0] {
        MD_CMD,
        MD_DATA,
        MD_CHECK
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_SEND
    } step_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [CODE_W-1:0] sel;
        logic [CODE_W-1:0] val;
    } cmd_dec_t;

    // Reset value code of configuration slot 'slot' (1-based).
    function automatic logic [CODE_W-1:0] slot_default(input int slot);
        return (slot == 2 || slot == 3) ? 3'b100 : 3'b000;
    endfunction

endpackage

// File: rtl/smc_cmd_decode.sv
// Combinational decoder for a byte received in command mode.
// Assumes the caller has already handled calibration and the data path;
// reserved codes map to K_NONE except the data-mode switch.
module smc_cmd_decode
    import smc_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_dec_t          dec
);

    // Classify the byte and pick the configuration slot field.
    always_comb begin
        dec.kind = K_NONE;
        dec.sel  = '0;
        dec.val  = cmd_byte[3:1];
        if (cmd_byte == CODE_GO_DATA) begin
            dec.kind = K_TO_DATA;
        end else if (cmd_byte == CODE_ESCAPE || cmd_byte == CODE_STOP) begin
            dec.kind = K_NONE;
        end else if (!cmd_byte[0]) begin
            dec.kind = K_NONE;
        end else if (cmd_byte[7]) begin
            unique case (cmd_byte[6:5])
                2'b00:   dec.kind = K_BIT;
                2'b01:   dec.kind = K_ACCEL;
                2'b10:   dec.kind = K_RESET;
                default: dec.kind = K_PULSE;
            endcase
        end else if (cmd_byte[6:4] != '0) begin
            dec.kind = K_CFG_WR;
            dec.sel  = cmd_byte[6:4];
        end else if (cmd_byte[3:1] != '0) begin
            dec.kind = K_CFG_RD;
            dec.sel  = cmd_byte[3:1];
        end
    end

endmodule

// File: rtl/smc_cfg_file.sv
// Configuration register file of SLOTS value codes, addressed 1..SLOTS.
// One slot (RSVD_SLOT) is read-only and keeps its reset code.
// Reset is synchronous and active low; reads are combinational.
module smc_cfg_file
    import smc_pkg::*;
#(
    parameter int SLOTS     = SLOT_CNT,
    parameter int CW        = CODE_W,
    parameter int RSVD_SLOT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_sel,
    input  logic [CW-1:0]       wr_code,
    input  logic [CW-1:0]       rd_sel,
    output logic [CW-1:0]       rd_code,
    output logic [SLOTS*CW-1:0] codes_flat
);

    localparam int FLAT_W = SLOTS * CW;

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        localparam int SLOT_ID = gi + 1;
        logic [CW-1:0] code_q;
        if (SLOT_ID == RSVD_SLOT) begin : g_ro
            // Reserved slot: pinned to its reset code.
            always_ff @(posedge clk) begin
                code_q <= CW'(slot_default(SLOT_ID));
            end
        end else begin : g_rw
            // Writable slot: load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    code_q <= CW'(slot_default(SLOT_ID));
                else if (wr_en && wr_sel == CW'(SLOT_ID))
                    code_q <= wr_code;
            end
        end
        assign codes_flat[gi*CW +: CW] = code_q;
    end

    // Read mux: unknown slot numbers read as zero.
    always_comb begin
        rd_code = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_sel == CW'(i + 1))
                rd_code = codes_flat[i*CW +: CW];
        end
    end

    logic unused_w;
    assign unused_w = ^FLAT_W;

endmodule

// File: rtl/sbus_mode_ctrl.sv
// Serial command/data mode controller.
// Takes host bytes on a ready/valid port and either executes them as
// commands or hands them to a bus engine through a request/done port.
// Sends at most one response at a time on a ready/valid byte port.
// Assumes eng_done is a single-cycle pulse while eng_req is high.
// Synchronous active-low reset; brk_det acts as a soft master reset.
module sbus_mode_ctrl
    import smc_pkg::*;
#(
    parameter logic [7:0] ARRIVAL_CODE = 8'hCD,
    parameter int         RSVD_SLOT    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    brk_det,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    output logic                    rx_ready,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    input  logic                    tx_ready,
    output logic                    eng_req,
    output logic [1:0]              eng_op,
    output logic [7:0]              eng_byte,
    output logic [1:0]              eng_speed,
    output logic                    eng_accel,
    output logic                    eng_spu_arm,
    output logic                    eng_pulse_hv,
    output logic                    eng_stop,
    input  logic                    eng_done,
    input  logic [7:0]              eng_result,
    input  logic                    eng_presence,
    output logic [SLOT_CNT*CODE_W-1:0] cfg_codes
);

    mode_e             mode_q;
    step_e             step_q;
    eng_op_e           op_q;
    logic              calib_q;
    logic [7:0]        tx_q;
    logic [7:0]        eng_byte_q;
    logic              req_q;
    logic              stop_q;
    logic [1:0]        speed_q;
    logic              accel_q;
    logic              arm_q;
    logic              hv_q;
    cmd_dec_t          dec;
    logic [CODE_W-1:0] rd_code;
    logic              rx_fire;
    logic              cmd_path;
    logic              cfg_we;
    logic              srst_n;

    assign srst_n = rst_n && !brk_det;

    smc_cmd_decode u_dec (
        .cmd_byte (rx_data),
        .dec      (dec)
    );

    smc_cfg_file #(
        .SLOTS     (SLOT_CNT),
        .CW        (CODE_W),
        .RSVD_SLOT (RSVD_SLOT)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (srst_n),
        .wr_en      (cfg_we),
        .wr_sel     (dec.sel),
        .wr_code    (dec.val),
        .rd_sel     (dec.sel),
        .rd_code    (rd_code),
        .codes_flat (cfg_codes)
    );

    // Byte intake is open when idle, or during a pulse to catch the stop code.
    assign rx_ready = (step_q == ST_IDLE) || (step_q == ST_BUS && op_q == OP_PULSE);
    assign rx_fire  = rx_valid && rx_ready;

    // A byte is executed as a command in command mode or when it ends a check.
    assign cmd_path = (mode_q == MD_CMD) ||
                      (mode_q == MD_CHECK && rx_data != CODE_ESCAPE);

    // Configuration write strobe for the register file.
    assign cfg_we = (step_q == ST_IDLE) && rx_fire && !calib_q && cmd_path &&
                    (dec.kind == K_CFG_WR);

    // Main sequencer: mode tracking, engine requests and responses.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            mode_q     <= MD_CMD;
            step_q     <= ST_IDLE;
            op_q       <= OP_BYTE;
            calib_q    <= 1'b1;
            tx_q       <= '0;
            eng_byte_q <= '0;
            req_q      <= 1'b0;
            stop_q     <= 1'b0;
            speed_q    <= '0;
            accel_q    <= 1'b0;
            arm_q      <= 1'b0;
            hv_q       <= 1'b0;
        end else begin
            stop_q <= 1'b0;
            unique case (step_q)
                ST_IDLE: begin
                    if (rx_fire) begin
                        if (calib_q) begin
                            calib_q <= 1'b0;
                        end else if (mode_q == MD_DATA) begin
                            if (rx_data == CODE_ESCAPE) begin
                                mode_q <= MD_CHECK;
                            end else begin
                                op_q       <= OP_BYTE;
                                eng_byte_q <= rx_data;
                                req_q      <= 1'b1;
                                step_q     <= ST_BUS;
                            end
                        end else if (mode_q == MD_CHECK && rx_data == CODE_ESCAPE) begin
                            mode_q     <= MD_DATA;
                            op_q       <= OP_BYTE;
                            eng_byte_q <= rx_data;
                            req_q      <= 1'b1;
                            step_q     <= ST_BUS;
                        end else begin
                            mode_q <= (dec.kind == K_TO_DATA) ? MD_DATA : MD_CMD;
                            unique case (dec.kind)
                                K_CFG_WR: begin
                                    tx_q   <= {rx_data[7:1], 1'b0};
                                    step_q <= ST_SEND;
                                end
                                K_CFG_RD: begin
                                    tx_q   <= {rx_data[7:4], rd_code, 1'b0};
                                    step_q <= ST_SEND;
                                end
                                K_ACCEL: begin
                                    accel_q <= rx_data[4];
                                    speed_q <= rx_data[3:2];
                                end
                                K_BIT, K_RESET: begin
                                    speed_q    <= rx_data[3:2];
                                    op_q       <= (dec.kind == K_BIT) ? OP_BIT : OP_RESET;
                                    eng_byte_q <= rx_data;
                                    req_q      <= 1'b1;
                                    step_q     <= ST_BUS;
                                end
                                K_PULSE: begin
                                    arm_q      <= rx_data[1];
                                    hv_q       <= rx_data[4];
                                    op_q       <= OP_PULSE;
                                    eng_byte_q <= rx_data;
                                    req_q      <= 1'b1;
                                    step_q     <= ST_BUS;
                                end
                                default: ;
                            endcase
                        end
                    end else if (mode_q == MD_CMD && !calib_q && eng_presence) begin
                        tx_q   <= ARRIVAL_CODE;
                        step_q <= ST_SEND;
                    end
                end
                ST_BUS: begin
                    if (eng_done) begin
                        req_q  <= 1'b0;
                        tx_q   <= (op_q == OP_PULSE) ? {eng_byte_q[7:2], 2'b00}
                                                     : eng_result;
                        step_q <= ST_SEND;
                    end else if (rx_fire && rx_data == CODE_STOP) begin
                        stop_q <= 1'b1;
                    end
                end
                ST_SEND: begin
                    if (tx_ready)
                        step_q <= ST_IDLE;
                end
                default: step_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_valid     = (step_q == ST_SEND);
    assign tx_data      = tx_q;
    assign eng_req      = req_q;
    assign eng_op       = op_q;
    assign eng_byte     = eng_byte_q;
    assign eng_speed    = speed_q;
    assign eng_accel    = accel_q;
    assign eng_spu_arm  = arm_q;
    assign eng_pulse_hv = hv_q;
    assign eng_stop     = stop_q;

endmodule

// File: rtl/smc_mode_ctrl_chk.sv
// Protocol checker for sbus_mode_ctrl, attached with bind.
// Assumes the same synchronous reset; brk_det also disables the checks.
module smc_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       brk_det,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       eng_req,
    input logic       eng_done,
    input logic [1:0] eng_op,
    input logic       eng_stop
);

    // R13: the request waits for done.
    p_req_held_r13: assert property (@(posedge clk) disable iff (!rst_n || brk_det)
        eng_req && !eng_done |=> eng_req);

    // R13: a stalled response keeps its value.
    p_tx_stable_r13: assert property (@(posedge clk) disable iff (!rst_n || brk_det)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R13: no byte intake while a response is pending.
    p_no_rx_in_send_r13: assert property (@(posedge clk) disable iff (!rst_n || brk_det)
        tx_valid |-> !rx_ready);

    // R9: a stop only appears during a pending pulse.
    p_stop_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n || brk_det)
        eng_stop |-> eng_req && eng_op == 2'd3);

    // R2: every new request follows an accepted host byte.
    p_req_from_rx_r2: assert property (@(posedge clk) disable iff (!rst_n || brk_det)
        $rose(eng_req) |-> $past(rx_valid && rx_ready));

endmodule

bind sbus_mode_ctrl smc_mode_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk_det  (brk_det),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .eng_req  (eng_req),
    .eng_done (eng_done),
    .eng_op   (eng_op),
    .eng_stop (eng_stop)
);

// File: tb/sbus_mode_ctrl_tb_top.sv
// Bench: table of host bytes with expected responses and engine traffic,
// then directed tests for reset, presence, pulse stop, back-pressure, break.
module sbus_mode_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        brk_det = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        eng_req;
    logic [1:0]  eng_op;
    logic [7:0]  eng_byte;
    logic [1:0]  eng_speed;
    logic        eng_accel;
    logic        eng_spu_arm;
    logic        eng_pulse_hv;
    logic        eng_stop;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_result = '0;
    logic        eng_presence = 1'b0;
    logic [20:0] cfg_codes;

    int          n_chk = 0;
    int          n_err = 0;
    int          resp_cnt = 0;
    logic [7:0]  resp_last = '0;
    int          eng_cnt = 0;
    logic [1:0]  eng_last_op = '0;
    logic [7:0]  eng_last_b = '0;
    int          stop_cnt = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    sbus_mode_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .brk_det      (brk_det),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_ready     (rx_ready),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_ready     (tx_ready),
        .eng_req      (eng_req),
        .eng_op       (eng_op),
        .eng_byte     (eng_byte),
        .eng_speed    (eng_speed),
        .eng_accel    (eng_accel),
        .eng_spu_arm  (eng_spu_arm),
        .eng_pulse_hv (eng_pulse_hv),
        .eng_stop     (eng_stop),
        .eng_done     (eng_done),
        .eng_result   (eng_result),
        .eng_presence (eng_presence),
        .cfg_codes    (cfg_codes)
    );

    // Fields: byte, has_resp, resp, has_eng, op, requirement number.
    localparam int NV = 23;
    localparam logic [23:0] VEC [NV] = '{
        {8'h2B, 1'b1, 8'h2A, 1'b0, 2'd0, 4'd5},   // R5 write slot 2 = 101
        {8'h05, 1'b1, 8'h0A, 1'b0, 2'd0, 4'd6},   // R6 read slot 2
        {8'h07, 1'b1, 8'h08, 1'b0, 2'd0, 4'd6},   // R6 read slot 3 default
        {8'h6F, 1'b1, 8'h6E, 1'b0, 2'd0, 4'd11},  // R11 write reserved slot
        {8'h0D, 1'b1, 8'h00, 1'b0, 2'd0, 4'd11},  // R11 reserved still 000
        {8'h2A, 1'b0, 8'h00, 1'b0, 2'd0, 4'd7},   // R7 config bit0 = 0
        {8'h01, 1'b0, 8'h00, 1'b0, 2'd0, 4'd7},   // R7 read of parameter 000
        {8'hC5, 1'b1, 8'h9F, 1'b1, 2'd2, 4'd8},   // R8 bus reset
        {8'h91, 1'b1, 8'hCB, 1'b1, 2'd1, 4'd8},   // R8 single bit
        {8'hB9, 1'b0, 8'h00, 1'b0, 2'd0, 4'd7},   // R7 accelerator control
        {8'h90, 1'b0, 8'h00, 1'b0, 2'd0, 4'd7},   // R7 comm byte bit0 = 0
        {8'hE3, 1'b0, 8'h00, 1'b0, 2'd0, 4'd7},   // R7 escape in command mode
        {8'hF1, 1'b0, 8'h00, 1'b0, 2'd0, 4'd7},   // R7 stop with no pulse
        {8'hE1, 1'b0, 8'h00, 1'b0, 2'd0, 4'd2},   // R2 to data mode
        {8'h3C, 1'b1, 8'h66, 1'b1, 2'd0, 4'd2},   // R2 data byte
        {8'hE1, 1'b1, 8'hBB, 1'b1, 2'd0, 4'd2},   // R2 E1h as data
        {8'hE3, 1'b0, 8'h00, 1'b0, 2'd0, 4'd3},   // R3 enter check
        {8'hE3, 1'b1, 8'hB9, 1'b1, 2'd0, 4'd3},   // R3 doubled escape
        {8'h00, 1'b1, 8'h5A, 1'b1, 2'd0, 4'd3},   // R3 back in data mode
        {8'hE3, 1'b0, 8'h00, 1'b0, 2'd0, 4'd4},   // R4 enter check
        {8'h07, 1'b1, 8'h08, 1'b0, 2'd0, 4'd4},   // R4 executed as command
        {8'h05, 1'b1, 8'h0A, 1'b0, 2'd0, 4'd4},   // R4 still command mode
        {8'hF3, 1'b1, 8'hF0, 1'b1, 2'd3, 4'd9}    // R9 pulse, natural end
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Response collector.
    initial begin
        forever begin
            @(negedge clk);
            if (tx_valid && tx_ready) begin
                resp_cnt++;
                resp_last = tx_data;
            end
        end
    end

    // Bus engine model: result = byte ^ 5Ah; pulses run 20 cycles unless stopped.
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                int  len;
                bit  stopped;
                eng_cnt++;
                eng_last_op = eng_op;
                eng_last_b  = eng_byte;
                len     = (eng_op == 2'd3) ? 20 : 4;
                stopped = 0;
                for (int k = 0; k < len && !stopped; k++) begin
                    @(negedge clk);
                    if (eng_stop) begin
                        stopped = 1;
                        stop_cnt++;
                    end
                end
                eng_result = eng_last_b ^ 8'h5A;
                eng_done   = 1'b1;
                @(negedge clk);
                eng_done   = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int r0;
        int e0;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        check(eng_req == 1'b0, "R1 eng_req", eng_req, 0);
        check(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
        // R6 defaults on cfg_codes
        check(cfg_codes == 21'h120, "R6 defaults", cfg_codes, 21'h120);
        // R1 calibration byte is silent
        send(8'h05);
        idle(30);
        check(resp_cnt == 0 && eng_cnt == 0, "R1 calibration", resp_cnt + eng_cnt, 0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [7:0] vb;
            logic       vhr;
            logic [7:0] vr;
            logic       vhe;
            logic [1:0] vop;
            logic [3:0] vrq;
            string      tag;
            {vb, vhr, vr, vhe, vop, vrq} = VEC[i];
            tag = $sformatf("R%0d vec%0d", vrq, i);
            r0 = resp_cnt;
            e0 = eng_cnt;
            send(vb);
            idle(40);
            check(resp_cnt == r0 + int'(vhr), {tag, " resp count"}, resp_cnt - r0, vhr);
            if (vhr)
                check(resp_last == vr, {tag, " resp value"}, resp_last, vr);
            check(eng_cnt == e0 + int'(vhe), {tag, " eng count"}, eng_cnt - e0, vhe);
            if (vhe)
                check(eng_last_op == vop && eng_last_b == vb, {tag, " eng op/byte"},
                      {eng_last_op, eng_last_b}, {vop, vb});
        end
        // R8 latched speed and accelerator flag
        check(eng_speed == 2'b10, "R8 speed", eng_speed, 2);
        check(eng_accel == 1'b1, "R8 accel", eng_accel, 1);
        // R9 pulse flags from F3h
        check(eng_spu_arm && eng_pulse_hv, "R9 pulse flags", {eng_spu_arm, eng_pulse_hv}, 3);

        // R10 presence in command mode
        r0 = resp_cnt;
        @(negedge clk); eng_presence = 1'b1;
        @(negedge clk); eng_presence = 1'b0;
        idle(5);
        check(resp_cnt == r0 + 1 && resp_last == 8'hCD, "R10 presence cmd", resp_last, 8'hCD);
        // R10 presence ignored in data mode
        send(8'hE1);
        r0 = resp_cnt;
        @(negedge clk); eng_presence = 1'b1;
        @(negedge clk); eng_presence = 1'b0;
        idle(5);
        check(resp_cnt == r0, "R10 presence data", resp_cnt - r0, 0);
        send(8'hE3);
        send(8'h05);
        idle(10);
        check(resp_last == 8'h0A, "R4 exit to command", resp_last, 8'h0A);

        // R9 pulse stopped early, stray byte discarded
        r0 = resp_cnt;
        e0 = stop_cnt;
        send(8'hE7);
        send(8'h05);
        send(8'hF1);
        idle(30);
        check(stop_cnt == e0 + 1, "R9 stop raised", stop_cnt - e0, 1);
        check(resp_cnt == r0 + 1 && resp_last == 8'hE4, "R9 pulse response",
              {resp_cnt - r0, resp_last}, {32'd1, 8'hE4});

        // R13 back-pressure
        tx_ready = 1'b0;
        send(8'h05);
        idle(5);
        check(tx_valid && tx_data == 8'h0A && !rx_ready, "R13 held response",
              {tx_valid, rx_ready, tx_data}, {1'b1, 1'b0, 8'h0A});
        idle(3);
        check(tx_valid && tx_data == 8'h0A, "R13 still held", tx_data, 8'h0A);
        tx_ready = 1'b1;
        idle(3);
        check(!tx_valid && rx_ready, "R13 released", {tx_valid, rx_ready}, 1);

        // R12 break restores defaults and calibration
        send(8'h23);
        idle(5);
        check(resp_last == 8'h22, "R5 write slot 2", resp_last, 8'h22);
        @(negedge clk); brk_det = 1'b1;
        @(negedge clk); brk_det = 1'b0;
        idle(2);
        check(eng_accel == 1'b0 && cfg_codes == 21'h120, "R12 state cleared",
              cfg_codes, 21'h120);
        r0 = resp_cnt;
        send(8'h05);
        idle(10);
        check(resp_cnt == r0, "R12 calibration again", resp_cnt - r0, 0);
        send(8'h05);
        idle(10);
        check(resp_cnt == r0 + 1 && resp_last == 8'h08, "R12 default read",
              resp_last, 8'h08);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule